// File: doc/BRIEF.md
# Request-Driven Counter With Start/Done Handshake

This block is an unsigned counter that advances only when an initiator asks for a new value. The initiator raises `start_i` for one cycle per request. Each accepted request moves through a short pipeline. The block pulses `done_o` when the request completes. One cycle later it shows the incremented count on `data_o`. The count persists from one request to the next, so successive requests return successive values.

A `stall_i` input freezes every pipeline stage. While the block is stalled, `busy_o` is high and any start request is refused. Because the initiation interval is one cycle, the block never reports busy for any other reason. Requests may therefore arrive on every cycle.

The block has a single clock and an active-low asynchronous reset. The reset clears the count and all pending requests.

Top module: `hsc_top`

## Requirements
- R1: After reset, `data_o` is 0 and `done_o` is 0. No `done_o` pulse appears until a start accepted after reset has reached the completing stage.
- R2: A start is accepted when `start_i` is 1 and `stall_i` is 0 at a rising edge. Each accepted start returns exactly one more than the previous result, so the first result after reset is 1.
- R3: The count is WIDTH bits wide and unsigned. An increment from the all-ones value gives 0.
- R4: `busy_o` is 0 whenever `stall_i` is 0. `busy_o` is 1 whenever `stall_i` is 1.
- R5: `done_o` is 1 for exactly one unstalled cycle per accepted start. That cycle is the first cycle after the acceptance edge in which `stall_i` is 0.
- R6: `data_o` takes the new value at the rising edge that ends the `done_o` cycle. The new value is therefore visible one cycle after `done_o`, or two cycles after an unstalled start.
- R7: While `stall_i` is 1, `done_o` is 0 and no stage advances. A start presented during stall is not accepted and never changes the count.
- R8: `data_o` keeps its value across every edge that does not end a `done_o` cycle.
- R9: Starts on consecutive cycles produce `done_o` on consecutive cycles and consecutive return values.
- R10: Driving `rst_n` low clears `data_o` and `done_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new count value |
| stall_i | input | 1 | Freeze all pipeline stages |
| busy_o | output | 1 | Requests cannot be taken this cycle |
| done_o | output | 1 | A request completes this cycle |
| data_o | output | WIDTH | Latest returned count |

## Verification
The bench builds the block with WIDTH set to 4. With that width, the wrap from 15 to 0 is reached after sixteen requests, so the counter's modular arithmetic is exercised directly within a short run. The same width keeps every value in the stall and back-to-back sequences small enough to enumerate cycle by cycle. Nothing in the logic depends on the width apart from the adder's size, so the results carry over to the 32-bit default.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  // Occupancy of the single request slot between acceptance and completion
  typedef enum logic {
    HSC_IDLE = 1'b0,
    HSC_PEND = 1'b1
  } hsc_slot_e;

  localparam int unsigned HSC_DEF_WIDTH = 32;
endpackage

// File: rtl/hsc_issue.sv
module hsc_issue
  import hsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      hold_i,
  output hsc_slot_e slot_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_o <= HSC_IDLE;
    end else if (!hold_i) begin
      slot_o <= start_i ? HSC_PEND : HSC_IDLE;
    end
  end

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(slot_o));
endmodule

// File: rtl/hsc_tally.sv
module hsc_tally #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (advance_i) begin
      count_o <= count_o + STEP;
    end
  end
endmodule

// File: rtl/hsc_top.sv
module hsc_top
  import hsc_pkg::*;
#(
  parameter int unsigned WIDTH = HSC_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stall_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] data_o
);
  hsc_slot_e slot;

  // Only a stall blocks intake: the initiation interval is one cycle
  assign busy_o = stall_i;
  assign done_o = (slot == HSC_PEND) && !stall_i;

  hsc_issue u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .hold_i  (stall_i),
    .slot_o  (slot)
  );

  hsc_tally #(.WIDTH(WIDTH)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance_i (done_o),
    .count_o   (data_o)
  );

  // R5
  accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) ##1 !stall_i |-> done_o);

  // R6
  done_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> data_o == $past(data_o) + WIDTH'(1));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(data_o));

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !done_o);

  // R4
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_i |-> !busy_o);
endmodule

// File: tb/hsc_top_test.sv
module hsc_top_test;
  localparam int unsigned W = 4;
  localparam int unsigned NV = 13;
  // bit 7 start, 6 stall, 5 expected done, 4 expected busy, 3:0 expected data
  localparam logic [7:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd0},
    {1'b1, 1'b0, 1'b1, 1'b0, 4'd0},
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd2},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'd2},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'd2},
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd2},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'd3},
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd3},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic stall_i = 1'b0;
  logic busy_o, done_o;
  logic [W-1:0] data_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hsc_top #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stall_i(stall_i),
    .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic exp_pend;
    logic [W-1:0] exp_cnt;
    logic wrapped;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", int'(data_o), 0);
    check("R1 done", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done idle", int'(done_o), 0);

    // R2 R4 R5 R6 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      start_i = VEC[i][7];
      stall_i = VEC[i][6];
      #1;
      check($sformatf("R5/R7 done v%0d", i), int'(done_o), int'(VEC[i][5]));
      check($sformatf("R4 busy v%0d", i), int'(busy_o), int'(VEC[i][4]));
      check($sformatf("R2/R6/R8 data v%0d", i), int'(data_o), int'(VEC[i][3:0]));
      @(negedge clk);
    end

    // R9 R3: back-to-back starts through the wrap
    exp_pend = 1'b0;
    exp_cnt = 4'd4;
    wrapped = 1'b0;
    for (int i = 0; i < 20; i++) begin
      start_i = (i < 18);
      stall_i = 1'b0;
      #1;
      check("R9 done", int'(done_o), int'(exp_pend));
      check("R9 data", int'(data_o), int'(exp_cnt));
      if (exp_pend) begin
        if (exp_cnt == 4'hF) wrapped = 1'b1;
        exp_cnt = exp_cnt + 4'd1;
      end
      exp_pend = start_i;
      @(negedge clk);
    end
    check("R3 wrap seen", int'(wrapped), 1);
    check("R3 data after wrap", int'(data_o), 6);

    // R10 asynchronous clear with a pending request
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    check("R10 data", int'(data_o), 0);
    check("R10 done", int'(done_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no done after reset", int'(done_o), 0);
    // R2 first result after reset is 1
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check("R2 first value", int'(data_o), 1);
    summary();
  end
endmodule